// File: doc/BRIEF.md
# Supersampled Tile Box-Filter Downsampler

This block turns a finished 32x32 supersampled tile into a 16x16 anti-aliased tile. The samples sit in four interleaved 16x16 banks. Each bank holds one of the four sub-pixel positions of every output pixel, so the four samples that make up one output pixel share a single bank address. Bank k holds the sample at supersampled row 2y + k[1] and column 2x + k[0].

The block waits for an end-of-tile trigger, which is raised once every triangle that touches the tile has been rendered. It then drives one shared read address to all four banks and walks that address once over the tile. For every address it averages the four returned samples per colour channel with equal weights. The 256 filtered pixels stream out in raster order with a valid strobe. A one-cycle done pulse marks the end of the tile. Filling the banks and storing the result in the framebuffer are left to neighbouring blocks.

Top module: `tile_downsampler`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `rd_en`, `pix_valid` and `done` are all low.
- R2: A `start` seen high at a clock edge while `busy` is low makes `busy` and `rd_en` high after that edge, with `rd_addr` equal to 0.
- R3: Once started, `rd_en` stays high for exactly 256 consecutive cycles, and `rd_addr` steps by one each cycle from 0 to 255.
- R4: Each output pixel packs red in bits 23:16, green in 15:8 and blue in 7:0. Each channel equals (s0 + s1 + s2 + s3 + 2) >> 2, where s0 to s3 are that channel of the four bank words read at one address, summed at 10 bits.
- R5: `pix_valid` rises exactly two cycles after the matching read address is driven, so there are 256 back-to-back valid pixels. `pix_x` carries address bits 3:0 and `pix_y` carries address bits 7:4, which gives raster order.
- R6: `done` is high for exactly one cycle, the cycle after the last pixel (x = 15, y = 15). `busy` falls in that same cycle.
- R7: A `start` seen while `busy` is high has no effect: the address walk and the pixel stream continue unchanged.
- R8: A `start` seen in the cycle where `done` is high is accepted, so a new tile begins with `rd_addr` = 0 in the next cycle.
- R9: The four bank data inputs are sampled one cycle after `rd_en`, which matches banks with a one-cycle registered read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | End-of-tile trigger; acted on only while idle |
| busy | output | 1 | High from the accepted start until the done cycle |
| rd_en | output | 1 | Read strobe shared by the four banks |
| rd_addr | output | 8 | Read address shared by the four banks |
| bank0_q | input | 24 | Bank 0 read word (even row, even column) |
| bank1_q | input | 24 | Bank 1 read word (even row, odd column) |
| bank2_q | input | 24 | Bank 2 read word (odd row, even column) |
| bank3_q | input | 24 | Bank 3 read word (odd row, odd column) |
| pix_valid | output | 1 | Output pixel strobe |
| pix_x | output | 4 | Output pixel column |
| pix_y | output | 4 | Output pixel row |
| pix_rgb | output | 24 | Filtered pixel, red in bits 23:16, blue in bits 7:0 |
| done | output | 1 | One-cycle end-of-tile pulse |

## Verification
The end of one tile and the acceptance of the next trigger can fall in the same cycle. The done pulse and the falling edge of busy share that cycle, and a start seen there must begin a new walk from address 0. The bench raises start exactly in the done cycle and then expects a full second tile with the address restarting at 0 and correct pixels. A start raised in the middle of a walk, and again on the cycle of the last read, must leave the address walk and the pixel stream untouched.

// File: rtl/tds_pkg.sv
package tds_pkg;

  // number of interleaved sub-pixel banks (2x2 box)
  localparam int unsigned N_BANK = 4;
  // log2 of the bank count: the averaging shift
  localparam int unsigned AVG_SH = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

endpackage

// File: rtl/tds_seq.sv
module tds_seq #(
  parameter int unsigned NPIX   = 256,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fin_i,
  output logic              busy_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              done_o
);
  import tds_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NPIX - 1);

  seq_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              addr_en;
  logic              done_q, done_n;

  // next-state logic
  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    addr_en = 1'b0;
    done_n  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_n = SEQ_READ;
          addr_n  = '0;
          addr_en = 1'b1;
        end
      end
      SEQ_READ: begin
        if (addr_q == LAST_ADDR) begin
          state_n = SEQ_DRAIN;
        end else begin
          addr_n  = addr_q + 1'b1;
          addr_en = 1'b1;
        end
      end
      SEQ_DRAIN: begin
        if (fin_i) begin
          state_n = SEQ_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_n;
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign rd_en_o   = (state_q == SEQ_READ);
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;

endmodule

// File: rtl/tds_avg.sv
module tds_avg #(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0] s0_i,
  input  logic [CH_W-1:0] s1_i,
  input  logic [CH_W-1:0] s2_i,
  input  logic [CH_W-1:0] s3_i,
  output logic [CH_W-1:0] avg_o
);
  import tds_pkg::*;

  localparam int unsigned SUM_W = CH_W + AVG_SH;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1 << (AVG_SH - 1));

  logic [SUM_W-1:0] sum_w;

  always_comb begin
    sum_w = SUM_W'(s0_i) + SUM_W'(s1_i) + SUM_W'(s2_i) + SUM_W'(s3_i);
    avg_o = CH_W'((sum_w + HALF) >> AVG_SH);
  end

endmodule

// File: rtl/tds_pipe.sv
module tds_pipe #(
  parameter int unsigned CH_W    = 8,
  parameter int unsigned N_CH    = 3,
  parameter int unsigned NPIX    = 256,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned COORD_W = 4,
  parameter int unsigned PIX_W   = CH_W * N_CH
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  input  logic [tds_pkg::N_BANK*PIX_W-1:0]  bank_i,
  output logic                              pix_valid_o,
  output logic [COORD_W-1:0]                pix_x_o,
  output logic [ADDR_W-COORD_W-1:0]         pix_y_o,
  output logic [PIX_W-1:0]                  pix_o,
  output logic                              fin_o
);
  import tds_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NPIX - 1);

  // stage 1: bank data arrives, address tag follows it
  logic              s1_vld_q;
  logic [ADDR_W-1:0] s1_addr_q;
  // stage 2: output register
  logic              out_vld_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic [PIX_W-1:0]  out_pix_q;
  logic [PIX_W-1:0]  avg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      s1_vld_q  <= rd_en_i;
      out_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_addr_q <= '0;
    end else if (rd_en_i) begin
      s1_addr_q <= rd_addr_i;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < N_CH; ch++) begin : g_ch
      tds_avg #(.CH_W(CH_W)) u_avg (
        .s0_i  (bank_i[0*PIX_W + ch*CH_W +: CH_W]),
        .s1_i  (bank_i[1*PIX_W + ch*CH_W +: CH_W]),
        .s2_i  (bank_i[2*PIX_W + ch*CH_W +: CH_W]),
        .s3_i  (bank_i[3*PIX_W + ch*CH_W +: CH_W]),
        .avg_o (avg_w[ch*CH_W +: CH_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr_q <= '0;
      out_pix_q  <= '0;
    end else if (s1_vld_q) begin
      out_addr_q <= s1_addr_q;
      out_pix_q  <= avg_w;
    end
  end

  assign pix_valid_o = out_vld_q;
  assign pix_x_o     = out_addr_q[COORD_W-1:0];
  assign pix_y_o     = out_addr_q[ADDR_W-1:COORD_W];
  assign pix_o       = out_pix_q;
  assign fin_o       = out_vld_q && (out_addr_q == LAST_ADDR);

endmodule

// File: rtl/tile_downsampler.sv
module tile_downsampler #(
  parameter int unsigned CH_W = 8,
  parameter int unsigned N_CH = 3,
  parameter int unsigned SIDE = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  output logic                              busy,
  output logic                              rd_en,
  output logic [$clog2(SIDE*SIDE)-1:0]      rd_addr,
  input  logic [CH_W*N_CH-1:0]              bank0_q,
  input  logic [CH_W*N_CH-1:0]              bank1_q,
  input  logic [CH_W*N_CH-1:0]              bank2_q,
  input  logic [CH_W*N_CH-1:0]              bank3_q,
  output logic                              pix_valid,
  output logic [$clog2(SIDE)-1:0]           pix_x,
  output logic [$clog2(SIDE)-1:0]           pix_y,
  output logic [CH_W*N_CH-1:0]              pix_rgb,
  output logic                              done
);
  import tds_pkg::*;

  localparam int unsigned NPIX    = SIDE * SIDE;
  localparam int unsigned ADDR_W  = $clog2(NPIX);
  localparam int unsigned COORD_W = $clog2(SIDE);
  localparam int unsigned PIX_W   = CH_W * N_CH;

  logic                     fin_w;
  logic [N_BANK*PIX_W-1:0]  bank_w;

  assign bank_w = {bank3_q, bank2_q, bank1_q, bank0_q};

  tds_seq #(
    .NPIX   (NPIX),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .fin_i     (fin_w),
    .busy_o    (busy),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .done_o    (done)
  );

  tds_pipe #(
    .CH_W    (CH_W),
    .N_CH    (N_CH),
    .NPIX    (NPIX),
    .ADDR_W  (ADDR_W),
    .COORD_W (COORD_W),
    .PIX_W   (PIX_W)
  ) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .bank_i      (bank_w),
    .pix_valid_o (pix_valid),
    .pix_x_o     (pix_x),
    .pix_y_o     (pix_y),
    .pix_o       (pix_rgb),
    .fin_o       (fin_w)
  );

endmodule

// File: rtl/tile_downsampler_chk.sv
module tile_downsampler_chk #(
  parameter int unsigned SIDE = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         rd_en,
  input logic [$clog2(SIDE*SIDE)-1:0] rd_addr,
  input logic                         pix_valid,
  input logic [$clog2(SIDE)-1:0]      pix_x,
  input logic [$clog2(SIDE)-1:0]      pix_y,
  input logic                         done
);
  localparam int unsigned NPIX   = SIDE * SIDE;
  localparam int unsigned ADDR_W = $clog2(NPIX);
  localparam int unsigned COORD_W = $clog2(SIDE);
  localparam logic [ADDR_W-1:0]  LAST_ADDR = ADDR_W'(NPIX - 1);
  localparam logic [COORD_W-1:0] LAST_XY   = COORD_W'(SIDE - 1);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != LAST_ADDR) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

  // R3
  walk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LAST_ADDR) |=> !rd_en);

  // R5
  pix_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(rd_en, 2));

  // R5
  pix_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en, 2) |-> pix_valid);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pix_valid) && $past(pix_x) == LAST_XY && $past(pix_y) == LAST_XY && !busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  read_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

endmodule

bind tile_downsampler tile_downsampler_chk #(.SIDE(SIDE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .pix_valid (pix_valid),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .done      (done)
);

// File: tb/tile_downsampler_bench.sv
module tile_downsampler_bench;
  localparam int CLK_P = 10;
  localparam int NPIX  = 256;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        busy, rd_en, pix_valid, done;
  logic [7:0]  rd_addr;
  logic [3:0]  pix_x, pix_y;
  logic [23:0] pix_rgb;
  logic [23:0] bank_q [4];
  logic [23:0] bmem [4][NPIX];

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  tile_downsampler u_tile_downsampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .bank0_q   (bank_q[0]),
    .bank1_q   (bank_q[1]),
    .bank2_q   (bank_q[2]),
    .bank3_q   (bank_q[3]),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_rgb   (pix_rgb),
    .done      (done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // bank model: one-cycle registered read (R9)
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int b = 0; b < 4; b++) bank_q[b] <= bmem[b][rd_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sample(input int pat, input int b, input int i, input int ch);
    case (pat)
      0: return 0;
      1: return 255;
      2: return (i * 7 + b * 53 + ch * 91 + i * i * 3 + 13) & 255;
      default: return (b == 0) ? (252 + ((i + ch) & 3)) : ((b == 1) ? 1 : 0);
    endcase
  endfunction

  task automatic fill(input int pat);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < NPIX; i++)
        bmem[b][i] = {8'(sample(pat, b, i, 2)), 8'(sample(pat, b, i, 1)), 8'(sample(pat, b, i, 0))};
  endtask

  function automatic int exp_pix(input int i);
    int r = 0;
    for (int ch = 0; ch < 3; ch++) begin
      int s = 0;
      for (int b = 0; b < 4; b++) s += int'(bmem[b][i][ch*8 +: 8]);
      r |= (((s + 2) / 4) & 255) << (ch * 8);
    end
    return r;
  endfunction

  // One tile. skip_start: start already accepted at the last edge.
  // poke: raise start during the walk (R7). chain: raise start in the done cycle (R8).
  task automatic run_tile(input int pat, input bit skip_start, input bit poke, input bit chain);
    if (!skip_start) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    // now in cycle c = 0, one cycle after the accepted start
    chk(busy == 1'b1 && rd_en == 1'b1, "R2", "busy/rd_en after start", int'({busy, rd_en}), 3);
    chk(rd_addr == 8'd0, "R2", "first address", int'(rd_addr), 0);
    for (int c = 1; c <= 259; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (c < NPIX) begin
        chk(rd_en && rd_addr == 8'(c), "R3", "address walk", int'(rd_addr), c);
      end else begin
        chk(!rd_en, "R3", "rd_en after walk", int'(rd_en), 0);
      end
      if (c >= 2 && c <= 257) begin
        int idx = c - 2;
        chk(pix_valid == 1'b1, "R5", "pix_valid", int'(pix_valid), 1);
        chk(pix_x == 4'(idx % 16) && pix_y == 4'(idx / 16), "R5", "raster coord",
            int'({pix_y, pix_x}), idx);
        chk(int'(pix_rgb) == exp_pix(idx), "R4", "pixel value", int'(pix_rgb), exp_pix(idx));
      end else if (c > 257) begin
        chk(pix_valid == 1'b0, "R5", "pix_valid after tile", int'(pix_valid), 0);
      end
      if (c == 258) begin
        chk(done == 1'b1, "R6", "done pulse", int'(done), 1);
        chk(busy == 1'b0, "R6", "busy falls with done", int'(busy), 0);
        if (chain) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          return;
        end
      end else begin
        chk(done == 1'b0, "R6", "done outside pulse", int'(done), 0);
      end
      if (c < 258) chk(busy == 1'b1, "R7", "busy during tile", int'(busy), 1);
      if (poke && (c == 50 || c == 255)) start = 1'b1;
    end
    chk(busy == 1'b0 && rd_en == 1'b0, "R8", "idle after tile", int'({busy, rd_en}), 0);
  endtask

  task automatic test_reset();
    start = 1'b0;
    rst_n = 1'b0;
    fill(0);
    repeat (3) @(negedge clk);
    chk({busy, rd_en, pix_valid, done} == 4'b0, "R1", "outputs in reset",
        int'({busy, rd_en, pix_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, rd_en, pix_valid, done} == 4'b0, "R1", "outputs after reset",
        int'({busy, rd_en, pix_valid, done}), 0);
  endtask

  task automatic test_idle_hold();
    repeat (5) @(negedge clk);
    chk({busy, rd_en, pix_valid, done} == 4'b0, "R1", "idle without start",
        int'({busy, rd_en, pix_valid, done}), 0);
  endtask

  initial begin
    test_reset();
    test_idle_hold();
    fill(0); run_tile(0, 1'b0, 1'b0, 1'b0);
    fill(1); run_tile(1, 1'b0, 1'b0, 1'b0);
    fill(2); run_tile(2, 1'b0, 1'b1, 1'b0);
    fill(3); run_tile(3, 1'b0, 1'b0, 1'b1);
    // R8: second tile started in the done cycle; same bank content
    run_tile(3, 1'b1, 1'b0, 1'b0);
    test_idle_hold();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule